// File: doc/BRIEF.md
# Far-End Fault Pattern Detector and Generator

This block watches a recovered serial code-bit stream on a fibre link for the far-end fault idle pattern. The pattern is a long run of ones closed by one zero. The block also puts that pattern on the transmit side when the local receiver has lost its signal. On the receive side it measures every run of ones. When enough back-to-back patterns have arrived, it raises a sticky remote-fault status and a blocking signal that the surrounding logic uses to hold off the MII transmit and receive data path. The serial management path is not touched.

Receive and transmit operate one code bit per clock. The first pattern of a sequence may be longer than nominal, because it can begin partway through ordinary idle ones. Every pattern after the first must have exactly the nominal length. The sticky status, and a copy of it on a second output, stays set until management reads it with a one-cycle strobe. The blocking signal follows the live stream instead. It drops once a full pattern period has passed with no valid pattern end.

Top module: `fefd_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), fault_stat, fault_stat_copy and mii_block are 0, and tx_bit equals tx_in.
- R2: fault_stat rises at the clock edge that samples the zero closing the REPEAT_MIN-th (default 3) consecutive valid pattern. It stays 0 after only REPEAT_MIN-1 patterns.
- R3: When no pattern is being counted, a run of at least RUN_LEN ones (default 84) followed by a zero counts as the first pattern. A shorter run does not count.
- R4: Once counting has started, each further pattern must be exactly RUN_LEN ones followed by one zero. A shorter run resets the count to zero, and so does a zero with no ones before it. A run that grows past RUN_LEN ones also resets the count, and is then treated as a new first-pattern candidate.
- R5: fault_stat holds until status_rd is high at a clock edge, and it clears at that edge. If a new detection happens at the same edge, the set wins.
- R6: fault_stat_copy always equals fault_stat.
- R7: mii_block rises together with fault_stat on a detection. It stays high while valid pattern ends keep arriving, and it falls at the edge that completes RUN_LEN+1 consecutive cycles with no valid pattern end.
- R8: While fault_en is 1 and sig_det is 0, tx_bit carries RUN_LEN ones and then one zero, repeated without a break. The first cycle of this mode is a one.
- R9: While fault_en is 0 or sig_det is 1, tx_bit equals tx_in in the same cycle. The fault pattern is never sent when fault_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one code bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_en | input | 1 | Enables transmission of the fault pattern |
| sig_det | input | 1 | Local signal detect, 1 when the receiver sees light |
| rx_bit | input | 1 | Recovered receive code bit |
| tx_in | input | 1 | Normal transmit code bit from the encoder |
| status_rd | input | 1 | One-cycle management read strobe that clears the sticky status |
| tx_bit | output | 1 | Transmit code bit after the fault-pattern mux |
| fault_stat | output | 1 | Sticky remote-fault status |
| fault_stat_copy | output | 1 | Second copy of the sticky status |
| mii_block | output | 1 | High while a far-end fault is live; blocks MII data activity |

## Verification
The bench builds the block with RUN_LEN=8 and REPEAT_MIN=3. A full pattern is then nine bits, so run lengths just below, at and just above the nominal value are quick to produce: a seven-run, an exact eight-run and a nine-run that crosses the limit. The short period also makes the RUN_LEN+1-cycle timeout that releases the blocking signal observable at its exact edge. On the transmit side, several whole pattern periods can be checked bit by bit. The repetition threshold keeps its default value, so the two-pattern and three-pattern cases are the ones the block uses in service.

// File: rtl/fefd_pkg.sv
// Package: shared types and helpers for the far-end fault detector.
// Assumes: nothing beyond IEEE 1800-2017.
package fefd_pkg;

    // Transmit mux selection.
    typedef enum logic {
        TXSEL_PASS  = 1'b0,
        TXSEL_FAULT = 1'b1
    } txsel_e;

    // Width needed to hold values 0..max_val.
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/fefd_rx_detect.sv
// Module: fefd_rx_detect
// Measures runs of ones on the receive stream and counts consecutive valid
// fault patterns. Gives a pulse for every valid pattern end (run_ok) and a
// pulse when the repetition threshold is reached (hit).
// Assumes: one code bit per clock; RUN_LEN >= 2, REPEAT_MIN >= 1.
module fefd_rx_detect #(
    parameter int RUN_LEN    = 84,
    parameter int REPEAT_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    output logic run_ok,
    output logic hit
);
    import fefd_pkg::*;

    localparam int ONES_MAX = RUN_LEN + 1;
    localparam int ONES_W   = cnt_width(ONES_MAX);
    localparam int REP_W    = cnt_width(REPEAT_MIN);
    localparam logic [ONES_W-1:0] LEN_V  = ONES_W'(RUN_LEN);
    localparam logic [ONES_W-1:0] SAT_V  = ONES_W'(ONES_MAX);
    localparam logic [REP_W-1:0]  REP_V  = REP_W'(REPEAT_MIN);
    localparam logic [REP_W-1:0]  HIT_AT = REP_W'(REPEAT_MIN - 1);

    logic [ONES_W-1:0] ones_q;
    logic [REP_W-1:0]  rep_q;

    // Decide whether the zero now arriving closes a valid pattern.
    always_comb begin
        if (rx_bit) begin
            run_ok = 1'b0;
        end else if (rep_q == '0) begin
            run_ok = (ones_q >= LEN_V);
        end else begin
            run_ok = (ones_q == LEN_V);
        end
        hit = run_ok && (rep_q >= HIT_AT);
    end

    // Track the current run length and the repetition count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones_q <= '0;
            rep_q  <= '0;
        end else if (rx_bit) begin
            if (ones_q != SAT_V) begin
                ones_q <= ones_q + 1'b1;
            end
            if ((ones_q == LEN_V) && (rep_q != '0)) begin
                rep_q <= '0;
            end
        end else begin
            ones_q <= '0;
            if (!run_ok) begin
                rep_q <= '0;
            end else if (rep_q != REP_V) begin
                rep_q <= rep_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fefd_status.sv
// Module: fefd_status
// Holds the sticky remote-fault status (cleared by a read strobe; a set wins
// over a read) and the live blocking flag, which is released after a full
// pattern period with no valid pattern end.
// Assumes: hit implies run_ok in the same cycle.
module fefd_status #(
    parameter int RUN_LEN = 84
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_ok,
    input  logic hit,
    input  logic status_rd,
    output logic fault_q,
    output logic block_q
);
    import fefd_pkg::*;

    localparam int GAP_W = cnt_width(RUN_LEN);
    localparam logic [GAP_W-1:0] GAP_END = GAP_W'(RUN_LEN);

    logic [GAP_W-1:0] gap_q;

    // Sticky status: set on a detection, cleared by a management read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (hit) begin
            fault_q <= 1'b1;
        end else if (status_rd) begin
            fault_q <= 1'b0;
        end
    end

    // Count cycles since the last valid pattern end, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (run_ok) begin
            gap_q <= '0;
        end else if (gap_q != GAP_END) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // Live blocking flag: set on detection, dropped after a silent period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            block_q <= 1'b0;
        end else if (hit) begin
            block_q <= 1'b1;
        end else if (!run_ok && (gap_q == GAP_END)) begin
            block_q <= 1'b0;
        end
    end

endmodule

// File: rtl/fefd_tx_gen.sv
// Module: fefd_tx_gen
// Sends RUN_LEN ones then one zero, repeated, in place of the normal
// transmit bit while fault sending is enabled and signal detect is lost.
// Assumes: the phase restarts every time the fault mode is entered.
module fefd_tx_gen #(
    parameter int RUN_LEN = 84
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_en,
    input  logic sig_det,
    input  logic tx_in,
    output logic tx_bit
);
    import fefd_pkg::*;

    localparam int PH_W = cnt_width(RUN_LEN);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(RUN_LEN);

    txsel_e          sel;
    logic [PH_W-1:0] phase_q;

    // Pick the transmit source.
    always_comb begin
        sel = (fault_en && !sig_det) ? TXSEL_FAULT : TXSEL_PASS;
    end

    // Advance the pattern phase while sending; hold at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (sel == TXSEL_PASS) begin
            phase_q <= '0;
        end else if (phase_q == PH_LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // Drive the output bit from the selected source.
    always_comb begin
        if (sel == TXSEL_FAULT) begin
            tx_bit = (phase_q != PH_LAST);
        end else begin
            tx_bit = tx_in;
        end
    end

endmodule

// File: rtl/fefd_top.sv
// Module: fefd_top
// Far-end fault detector and generator for a serial code-bit stream.
// The receive detector feeds the status block; the transmit generator is
// independent of the receive side.
// Assumes: one code bit per clock in both directions.
module fefd_top #(
    parameter int RUN_LEN    = 84,
    parameter int REPEAT_MIN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_en,
    input  logic sig_det,
    input  logic rx_bit,
    input  logic tx_in,
    input  logic status_rd,
    output logic tx_bit,
    output logic fault_stat,
    output logic fault_stat_copy,
    output logic mii_block
);

    logic run_ok;
    logic hit;
    logic fault_q;
    logic block_q;

    fefd_rx_detect #(
        .RUN_LEN   (RUN_LEN),
        .REPEAT_MIN(REPEAT_MIN)
    ) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_bit(rx_bit),
        .run_ok(run_ok),
        .hit   (hit)
    );

    fefd_status #(
        .RUN_LEN(RUN_LEN)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_ok   (run_ok),
        .hit      (hit),
        .status_rd(status_rd),
        .fault_q  (fault_q),
        .block_q  (block_q)
    );

    fefd_tx_gen #(
        .RUN_LEN(RUN_LEN)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault_en(fault_en),
        .sig_det (sig_det),
        .tx_in   (tx_in),
        .tx_bit  (tx_bit)
    );

    // Route the status onto both status outputs.
    always_comb begin
        fault_stat      = fault_q;
        fault_stat_copy = fault_q;
        mii_block       = block_q;
    end

endmodule

// File: rtl/fefd_chk.sv
// Module: fefd_chk
// Port-level properties of fefd_top, attached with bind.
module fefd_chk (
    input logic clk,
    input logic rst_n,
    input logic fault_en,
    input logic sig_det,
    input logic rx_bit,
    input logic tx_in,
    input logic status_rd,
    input logic tx_bit,
    input logic fault_stat,
    input logic mii_block
);

    // R9: passthrough whenever fault sending is not active
    assert_tx_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_en || sig_det) |-> (tx_bit == tx_in));

    // R5: the sticky status only falls after a read strobe
    assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_stat) |-> $past(status_rd));

    // R7: a new status always comes with the blocking flag
    assert_flag_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_stat) |-> mii_block);

    // R2: detection is triggered by a zero that closes a run
    assert_detect_on_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mii_block) |-> !$past(rx_bit));

    // R8: a sent zero is always followed by a one while still sending
    assert_single_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_en && !sig_det && $past(fault_en && !sig_det && !tx_bit))
        |-> tx_bit);

endmodule

bind fefd_top fefd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_en  (fault_en),
    .sig_det   (sig_det),
    .rx_bit    (rx_bit),
    .tx_in     (tx_in),
    .status_rd (status_rd),
    .tx_bit    (tx_bit),
    .fault_stat(fault_stat),
    .mii_block (mii_block)
);

// File: tb/fefd_top_tb_top.sv
// Bench: directed scenarios, one task each; inputs change on the falling
// edge and outputs are checked on the falling edge.
module fefd_top_tb_top;

    localparam int RL = 8;
    localparam int RM = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fault_en = 1'b0;
    logic sig_det = 1'b1;
    logic rx_bit = 1'b0;
    logic tx_in = 1'b0;
    logic status_rd = 1'b0;
    logic tx_bit;
    logic fault_stat;
    logic fault_stat_copy;
    logic mii_block;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fefd_top #(.RUN_LEN(RL), .REPEAT_MIN(RM)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .fault_en       (fault_en),
        .sig_det        (sig_det),
        .rx_bit         (rx_bit),
        .tx_in          (tx_in),
        .status_rd      (status_rd),
        .tx_bit         (tx_bit),
        .fault_stat     (fault_stat),
        .fault_stat_copy(fault_stat_copy),
        .mii_block      (mii_block)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one receive bit now (at a falling edge) and move to the next.
    task automatic send_bit(input logic b);
        rx_bit = b;
        @(negedge clk);
    endtask

    task automatic send_run(input int ones);
        for (int i = 0; i < ones; i++) send_bit(1'b1);
        send_bit(1'b0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rx_bit = 1'b0; status_rd = 1'b0;
        fault_en = 1'b0; sig_det = 1'b1; tx_in = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 fault_stat", fault_stat, 0);
        check("R1 mii_block", mii_block, 0);
        check("R1 copy", fault_stat_copy, 0);
        tx_in = 1'b1; #1;
        check("R1 tx_bit", tx_bit, 1);
    endtask

    task automatic t_three_needed();
        do_reset();
        send_run(RL); send_run(RL);
        check("R2 two patterns", fault_stat, 0);
        send_run(RL);
        check("R2 three patterns", fault_stat, 1);
        check("R6 copy", fault_stat_copy, 1);
        check("R7 block set", mii_block, 1);
        send_run(RL); send_run(RL);
        check("R7 block held", mii_block, 1);
        for (int i = 0; i < RL; i++) send_bit(1'b0);
        check("R7 block before timeout", mii_block, 1);
        send_bit(1'b0);
        check("R7 block released", mii_block, 0);
        check("R5 status sticky", fault_stat, 1);
        status_rd = 1'b1; @(negedge clk); status_rd = 1'b0;
        check("R5 read clears", fault_stat, 0);
        check("R6 copy cleared", fault_stat_copy, 0);
    endtask

    task automatic t_first_run();
        do_reset();
        send_run(RL - 1); send_run(RL); send_run(RL);
        check("R3 short first run", fault_stat, 0);
        send_run(RL);
        check("R3 after valid third", fault_stat, 1);
        do_reset();
        send_run(3 * RL); send_run(RL); send_run(RL);
        check("R3 long first run", fault_stat, 1);
    endtask

    task automatic t_later_runs();
        do_reset();
        send_run(RL); send_run(RL - 3); send_run(RL); send_run(RL);
        check("R4 short later run", fault_stat, 0);
        send_run(RL);
        check("R4 recount short", fault_stat, 1);
        do_reset();
        send_run(RL); send_bit(1'b0); send_run(RL); send_run(RL);
        check("R4 double zero", fault_stat, 0);
        do_reset();
        send_run(RL); send_run(RL + 1); send_run(RL);
        check("R4 long later run", fault_stat, 0);
        send_run(RL);
        check("R4 long run as first", fault_stat, 1);
    endtask

    task automatic t_set_wins();
        do_reset();
        send_run(RL); send_run(RL);
        for (int i = 0; i < RL; i++) send_bit(1'b1);
        status_rd = 1'b1;
        send_bit(1'b0);
        status_rd = 1'b0;
        check("R5 set wins over read", fault_stat, 1);
    endtask

    task automatic t_tx();
        do_reset();
        fault_en = 1'b1; sig_det = 1'b0; tx_in = 1'b0;
        for (int k = 0; k < 3 * (RL + 1); k++) begin
            #1;
            check("R8 pattern bit", tx_bit, (k % (RL + 1) != RL) ? 1 : 0);
            @(negedge clk);
        end
        sig_det = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tx_in = k[0]; #1;
            check("R9 sig_det passthrough", tx_bit, k % 2);
            @(negedge clk);
        end
        fault_en = 1'b0; sig_det = 1'b0;
        for (int k = 0; k < 4; k++) begin
            tx_in = ~k[0]; #1;
            check("R9 disabled passthrough", tx_bit, 1 - (k % 2));
            @(negedge clk);
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_three_needed();
        t_first_run();
        t_later_runs();
        t_set_wins();
        t_tx();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule